// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Coded Prescaler

This block holds a bank of independent waveform channels, all timed from one reference clock (nominally 24 MHz). Each channel turns a 4-bit divider code into one of eleven fixed division ratios. The divided ticks step a counter, and the counter shapes a pulse train whose length, duty and active level come from per-channel fields. A bypass option sends the reference clock itself to a channel's pin. A running channel does not use newly written timing values straight away. It holds them in shadow storage and applies them at the next cycle boundary, so a period is never cut short or torn.

Software programs the channels through a plain synchronous write port. It inspects them through a read port that has one cycle of latency. The read port also shows a per-channel flag that stays set while shadowed values wait to be applied.

Top module: `pwm_bank`

## Requirements
- R1: The divider code selects the number of reference cycles per tick: code 15 gives 1, 0 gives 120, 1 gives 180, 2 gives 240, 3 gives 360, 4 gives 480, 8 gives 12000, 9 gives 24000, 10 gives 36000, 11 gives 48000 and 12 gives 72000.
- R2: Codes 5, 6, 7, 13 and 14 freeze the channel's counter at zero and hold its output at the inactive level. If a valid code is then written, it is applied in the following cycle.
- R3: One waveform cycle lasts (period field + 1) ticks. The output is active while the tick count is below the active field, starting from count 0, and is inactive for the rest of the cycle.
- R4: An active field greater than the period field keeps the output active for the whole cycle. An active field of 0 keeps it inactive.
- R5: Control bit 3 (polarity) selects the active level: 0 means high and 1 means low. The inactive level is the opposite.
- R6: When control bit 2 (bypass) is set on a running channel, its output equals the reference clock, whatever the divider code, period and active fields hold.
- R7: A channel runs only while both control bit 0 (gate) and control bit 1 (enable) are set. Clearing either bit drives the inactive level and resets the counter, so the next start begins at count 0 with the active part.
- R8: While a channel runs, writes to its period, active or divider fields are held in shadow storage. Its busy flag (status bit 0) then reads 1 until the values are applied at the next cycle boundary. While the channel is stopped, written values apply at once and busy reads 0.
- R9: Every channel keeps its own fields, counter and output. Traffic on one channel does not change another channel.
- R10: Field select 0 is control (bit 0 gate, bit 1 enable, bit 2 bypass, bit 3 polarity, bits 7:4 divider code). Select 1 is period, select 2 is active and select 3 is status. A read returns the addressed value on the clock edge after the address is presented. Writes to select 3 are ignored.
- R11: After reset, all fields are 0, every output is low and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also forwarded in bypass |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | CH_W (2) | Channel addressed by a write |
| wr_sel | input | 2 | Field addressed by a write |
| wr_data | input | CNT_W (16) | Write data |
| rd_ch | input | CH_W (2) | Channel addressed by a read |
| rd_sel | input | 2 | Field addressed by a read |
| rd_data | output | CNT_W (16) | Registered read data |
| pwm_out | output | NUM_CH (4) | One waveform output per channel |

## Verification
The assertions assume that reset is held for at least one edge. They assume that the write inputs are stable around each rising edge and that only select values 0 to 3 are driven. They also assume that the only path to a channel's state is the write port, so that a new period can appear only at a cycle boundary or while the channel is stopped. The bench meets these conditions by changing every input on the falling edge, one write at a time. All shadowed updates are issued through the same write task. Bypass is checked on both clock phases rather than only on the falling edge, because its output is the clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CODE_W = 4;
    localparam int DIV_W  = 17;
    localparam int CTRL_W = 8;

    // Control word bit positions
    localparam int CB_GATE = 0;
    localparam int CB_EN   = 1;
    localparam int CB_BYP  = 2;
    localparam int CB_POL  = 3;
    localparam int CB_CODE = 4;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_ACTIVE = 2'd2,
        SEL_STATUS = 2'd3
    } field_sel_e;

    // Reference cycles per tick; zero marks an unused code
    function automatic logic [DIV_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            4'd15:   r = DIV_W'(1);
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic code_valid(input logic [CODE_W-1:0] code);
        return code_ratio(code) != '0;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [DW-1:0] ratio;
    logic          valid;
    logic [DW-1:0] div_d, div_q;

    always_comb begin
        ratio = DW'(code_ratio(code));
        valid = ratio != '0;
        div_d = div_q;
        tick  = 1'b0;
        if (!run || !valid) begin
            div_d = '0;
        end else if (div_q == ratio - DW'(1)) begin
            div_d = '0;
            tick  = 1'b1;
        end else begin
            div_d = div_q + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R1: the divider never passes the ratio of the applied code
    a_r1_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && valid) |-> (div_q < ratio));

    // R2: an unused code keeps the divider parked
    a_r2_div_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid) |=> (div_q == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic [CNT_W-1:0] ctrl_word,
    output logic [CNT_W-1:0] period_word,
    output logic [CNT_W-1:0] active_word,
    output logic             busy
);

    localparam int PAD_W = CNT_W - CTRL_W;

    typedef struct packed {
        logic              gate;
        logic              en;
        logic              byp;
        logic              pol;
        logic [CODE_W-1:0] code_sh;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  per_sh;
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  act_sh;
        logic [CNT_W-1:0]  act;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
    } chan_s;

    chan_s s_d, s_q;
    logic  run, code_ok, tick, boundary, lvl;

    assign run     = s_q.gate & s_q.en;
    assign code_ok = code_valid(s_q.code);

    pwm_prescale #(.DW(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (s_q.code),
        .tick  (tick)
    );

    always_comb begin
        s_d      = s_q;
        boundary = tick && (s_q.cnt == s_q.per);

        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    s_d.gate    = wr_data[CB_GATE];
                    s_d.en      = wr_data[CB_EN];
                    s_d.byp     = wr_data[CB_BYP];
                    s_d.pol     = wr_data[CB_POL];
                    s_d.code_sh = wr_data[CB_CODE +: CODE_W];
                    s_d.busy    = 1'b1;
                end
                SEL_PERIOD: begin
                    s_d.per_sh = wr_data;
                    s_d.busy   = 1'b1;
                end
                SEL_ACTIVE: begin
                    s_d.act_sh = wr_data;
                    s_d.busy   = 1'b1;
                end
                default: ;
            endcase
        end

        if (!run || !code_ok) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = boundary ? '0 : s_q.cnt + CNT_W'(1);
        end

        if (!run || !code_ok || boundary) begin
            s_d.code = s_d.code_sh;
            s_d.per  = s_d.per_sh;
            s_d.act  = s_d.act_sh;
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl     = run && code_ok && (s_q.cnt < s_q.act);
    assign pwm_out = (run && s_q.byp) ? clk : (lvl ^ s_q.pol);

    assign ctrl_word   = {{PAD_W{1'b0}}, s_q.code_sh, s_q.pol, s_q.byp, s_q.en, s_q.gate};
    assign period_word = s_q.per_sh;
    assign active_word = s_q.act_sh;
    assign busy        = s_q.busy;

    // R7: a stopped channel sits at its inactive level
    a_r7_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> (pwm_out == s_q.pol));

    // R8: a stopped channel clears busy on the next edge
    a_r8_idle_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (!s_q.busy));

    // R8: a new period is applied only where the count restarts
    a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.per != $past(s_q.per)) |-> (s_q.cnt == '0));

    // R3: the counter stays inside the cycle
    a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.per);

    // R4: an active field above the period means full duty
    a_r4_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (run && code_ok && !s_q.byp && (s_q.act > s_q.per)) |-> (pwm_out != s_q.pol));

    // R2: an unused code holds the inactive level
    a_r2_bad_code_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !code_ok && !s_q.byp) |-> (pwm_out == s_q.pol));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic [1:0]        rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [CNT_W-1:0]  ctrl_a [NUM_CH];
    logic [CNT_W-1:0]  per_a  [NUM_CH];
    logic [CNT_W-1:0]  act_a  [NUM_CH];
    logic [NUM_CH-1:0] busy_a;
    logic [CNT_W-1:0]  rd_d, rd_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(g));

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (hit),
            .wr_sel      (wr_sel),
            .wr_data     (wr_data),
            .pwm_out     (pwm_out[g]),
            .ctrl_word   (ctrl_a[g]),
            .period_word (per_a[g]),
            .active_word (act_a[g]),
            .busy        (busy_a[g])
        );
    end

    always_comb begin
        rd_d = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                case (rd_sel)
                    SEL_CTRL:   rd_d = ctrl_a[i];
                    SEL_PERIOD: rd_d = per_a[i];
                    SEL_ACTIVE: rd_d = act_a[i];
                    default:    rd_d = {{(CNT_W-1){1'b0}}, busy_a[i]};
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R10: status reads carry only the busy bit
    a_r10_status_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_sel) == SEL_STATUS) |-> (rd_data[CNT_W-1:1] == '0));

endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [1:0]       wr_ch;
    logic [1:0]       wr_sel;
    logic [CNT_W-1:0] wr_data;
    logic [1:0]       rd_ch;
    logic [1:0]       rd_sel;
    logic [CNT_W-1:0] rd_data;
    logic [NUM_CH-1:0] pwm_out;

    always #2 clk = ~clk;

    pwm_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_ch(rd_ch),
        .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    typedef struct {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] exp;
        string             tag;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares one queued item per falling edge
    always begin
        item_t it;
        @(negedge clk);
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(it.tag, 32'(pwm_out & it.mask), 32'(it.exp & it.mask));
        end
    end

    function automatic logic wave_bit(int i, int ratio, int per, int act, logic pol);
        int c;
        c = (i / ratio) % (per + 1);
        return (c < act) ^ pol;
    endfunction

    function automatic logic [15:0] ctrl(logic gate, logic en, logic byp, logic pol, logic [3:0] code);
        return {8'h00, code, pol, byp, en, gate};
    endfunction

    task automatic write_reg(input int ch, input int sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input int ch, input int sel, output logic [15:0] data);
        @(negedge clk);
        rd_ch = 2'(ch); rd_sel = 2'(sel);
        @(negedge clk);
        data = rd_data;
    endtask

    task automatic push_wave(input int ch, input int start, input int n, input int ratio,
                             input int per, input int act, input logic pol, input string tag);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.mask = '0; it.exp = '0;
            it.mask[ch] = 1'b1;
            it.exp[ch]  = wave_bit(start + k, ratio, per, act, pol);
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_sel = '0; wr_data = '0;
        rd_ch = '0; rd_sel = 2'd3;
        repeat (3) @(negedge clk);
        check("R11 outputs after reset", 32'(pwm_out), 32'h0);
        check("R11 read data after reset", 32'(rd_data), 32'h0);
        rst_n = 1'b1;
        read_reg(2, 1, rv);
        check("R11 period field after reset", 32'(rv), 32'h0);

        // R3: basic waveform, divide by 1
        write_reg(0, 1, 16'd9);
        write_reg(0, 2, 16'd4);
        write_reg(0, 0, ctrl(1, 1, 0, 0, 4'd15));
        push_wave(0, 0, 30, 1, 9, 4, 1'b0, "R3 period 10 active 4");
        drain();

        // R8: shadowed update while running
        write_reg(0, 0, ctrl(0, 0, 0, 0, 4'd15));
        rd_ch = 2'd0; rd_sel = 2'd3;
        write_reg(0, 0, ctrl(1, 1, 0, 0, 4'd15));
        write_reg(0, 1, 16'd3);
        write_reg(0, 2, 16'd1);
        push_wave(0, 4, 6, 1, 9, 4, 1'b0, "R8 old values until boundary");
        push_wave(0, 0, 8, 1, 3, 1, 1'b0, "R8 new values after boundary");
        #1 check("R8 busy while pending", 32'(rd_data[0]), 32'h1);
        drain();
        check("R8 busy cleared after boundary", 32'(rd_data[0]), 32'h0);

        // R5: inverted polarity
        write_reg(0, 0, ctrl(0, 0, 0, 1, 4'd15));
        write_reg(0, 1, 16'd4);
        write_reg(0, 2, 16'd2);
        write_reg(0, 0, ctrl(1, 1, 0, 1, 4'd15));
        push_wave(0, 0, 15, 1, 4, 2, 1'b1, "R5 active-low waveform");
        drain();

        // R7: enable cleared, restart, gate cleared
        write_reg(0, 0, ctrl(1, 0, 0, 1, 4'd15));
        push_wave(0, 0, 5, 1, 0, 0, 1'b1, "R7 enable cleared inactive");
        drain();
        write_reg(0, 0, ctrl(1, 1, 0, 1, 4'd15));
        push_wave(0, 0, 10, 1, 4, 2, 1'b1, "R7 restart from count 0");
        drain();
        write_reg(0, 0, ctrl(0, 1, 0, 1, 4'd15));
        push_wave(0, 0, 4, 1, 0, 0, 1'b1, "R7 gate cleared inactive");
        drain();

        // R4: full and zero duty
        write_reg(0, 0, ctrl(0, 0, 0, 0, 4'd15));
        write_reg(0, 1, 16'd3);
        write_reg(0, 2, 16'd7);
        write_reg(0, 0, ctrl(1, 1, 0, 0, 4'd15));
        push_wave(0, 0, 12, 1, 0, 1, 1'b0, "R4 active above period");
        drain();
        write_reg(0, 0, ctrl(0, 0, 0, 0, 4'd15));
        write_reg(0, 2, 16'd0);
        write_reg(0, 0, ctrl(1, 1, 0, 0, 4'd15));
        push_wave(0, 0, 12, 1, 0, 0, 1'b0, "R4 active zero");
        drain();

        // R1: coded divide ratios
        write_reg(0, 0, ctrl(0, 0, 0, 0, 4'd15));
        write_reg(0, 1, 16'd1);
        write_reg(0, 2, 16'd1);
        write_reg(0, 0, ctrl(1, 1, 0, 0, 4'd0));
        push_wave(0, 0, 480, 120, 1, 1, 1'b0, "R1 code 0 ratio 120");
        drain();
        write_reg(0, 0, ctrl(0, 0, 0, 0, 4'd0));
        write_reg(0, 0, ctrl(1, 1, 0, 0, 4'd4));
        push_wave(0, 0, 1920, 480, 1, 1, 1'b0, "R1 code 4 ratio 480");
        drain();

        // R2: unused code, then valid code applied at once
        write_reg(0, 0, ctrl(0, 0, 0, 1, 4'd4));
        write_reg(0, 1, 16'd9);
        write_reg(0, 2, 16'd5);
        write_reg(0, 0, ctrl(1, 1, 0, 1, 4'd6));
        push_wave(0, 0, 20, 1, 0, 0, 1'b1, "R2 unused code holds inactive");
        drain();
        write_reg(0, 0, ctrl(1, 1, 0, 1, 4'd15));
        push_wave(0, 0, 20, 1, 9, 5, 1'b1, "R2 valid code resumes");
        drain();

        // R6: bypass forwards the clock
        write_reg(0, 0, ctrl(1, 1, 1, 0, 4'd6));
        for (int k = 0; k < 4; k++) begin
            #1 check("R6 bypass low phase", 32'(pwm_out[0]), 32'h0);
            @(posedge clk);
            #1 check("R6 bypass high phase", 32'(pwm_out[0]), 32'h1);
            @(negedge clk);
        end
        write_reg(0, 0, ctrl(0, 0, 0, 0, 4'd15));

        // R9: two channels at once, others idle
        write_reg(1, 1, 16'd5);
        write_reg(1, 2, 16'd2);
        write_reg(2, 1, 16'd2);
        write_reg(2, 2, 16'd1);
        write_reg(1, 0, ctrl(1, 1, 0, 0, 4'd15));
        write_reg(2, 0, ctrl(1, 1, 0, 1, 4'd15));
        for (int k = 0; k < 24; k++) begin
            item_t it;
            it.mask = 4'b1111;
            it.exp  = {1'b0, wave_bit(k, 1, 2, 1, 1'b1), wave_bit(k + 2, 1, 5, 2, 1'b0), 1'b0};
            it.tag  = "R9 independent channels";
            sb_q.push_back(it);
        end
        drain();

        // R10: register map and ignored status write
        write_reg(3, 1, 16'h1234);
        write_reg(3, 2, 16'h0042);
        write_reg(3, 0, ctrl(0, 0, 1, 1, 4'd9));
        read_reg(3, 1, rv);
        check("R10 period readback", 32'(rv), 32'h1234);
        read_reg(3, 2, rv);
        check("R10 active readback", 32'(rv), 32'h0042);
        read_reg(3, 0, rv);
        check("R10 control readback", 32'(rv), 32'h009C);
        write_reg(3, 3, 16'hFFFF);
        read_reg(3, 3, rv);
        check("R10 status write ignored", 32'(rv), 32'h0);
        read_reg(3, 0, rv);
        check("R10 control after status write", 32'(rv), 32'h009C);
        read_reg(3, 1, rv);
        check("R10 period after status write", 32'(rv), 32'h1234);
        check("R10 stopped output at polarity level", 32'(pwm_out[3]), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule